// File: doc/BRIEF.md
# Bus Acknowledge Timeout Monitor

This block supervises every access on a pipelined system bus, whichever master started it. An access begins with a transfer start strobe and then passes through two handshakes. The first is the address acknowledge that closes the address phase. The second is the final data acknowledge that closes the data phase. Each phase has its own timer, measured in units of eight bus clocks against one programmable limit. If the awaited acknowledge does not arrive within that limit, the block emits a one-cycle transfer error strobe. This strobe ends the stalled access, and the monitor then returns to idle.

The monitor tracks one access at a time. While an access is open, further start strobes are ignored. An enable input turns the whole function off. While it is off, no error is ever raised, and an access that was open when it went off is abandoned.

Top module: `bus_ack_watchdog`

## Requirements
- R1: After reset, `xfer_err` is low and the monitor is idle.
- R2: Let N be the phase limit in clocks, 8 × `limit_units`. If `aack` is not sampled high in any of the N clock edges after the edge that sampled `xfer_start`, then `xfer_err` is high for the cycle that follows the N-th such edge.
- R3: An `aack` sampled on any of those N edges, including the N-th, ends the address phase without an error.
- R4: The data phase is timed from the edge that sampled `aack`. If `dack` is not sampled high within the next N edges, `xfer_err` rises after the N-th of those edges.
- R5: A `dack` sampled on any of those N edges, including the N-th, ends the access without an error.
- R6: A `limit_units` value of 0 means 256 units, so N is 2048 clocks.
- R7: While `mon_en` is low, `xfer_err` stays low. An access that is open when `mon_en` falls is abandoned and raises no error later.
- R8: A `xfer_start` sampled while an access is open is ignored. It does not restart the timer and does not open a second access.
- R9: `xfer_err` is high for exactly one cycle. The monitor is then idle, and no further error occurs without a new `xfer_start`.
- R10: If `aack` and `dack` are sampled together in the address phase, the access ends at once without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Monitor enable; low disables all timing |
| xfer_start | input | 1 | Transfer start strobe, from an internal or an external master |
| aack | input | 1 | Address acknowledge |
| dack | input | 1 | Final data acknowledge of the access |
| limit_units | input | LIMIT_W | Timeout limit in units of 2^UNIT_SHIFT clocks; 0 selects the maximum |
| xfer_err | output | 1 | One-cycle transfer error strobe |

## Verification
The bench targets the exact boundary cycle of each phase. An acknowledge on the N-th edge must still win, and a design that compares with an off-by-one bound fires one cycle early or late. It also checks the zero limit: a design that treats zero literally errors almost at once instead of after 2048 clocks. A second start during an open access catches a design that restarts the timer, because that design moves the error cycle later. Dropping the enable mid-access catches a design that keeps its timer state and fires once it is re-enabled.

// File: rtl/bw_pkg.sv
package bw_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } bw_phase_e;
endpackage

// File: rtl/bw_tick_gen.sv
// Divides running clocks into units of 2^SHIFT; tick marks the last clock of a unit.
module bw_tick_gen #(
   parameter int SHIFT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   generate
      if (SHIFT == 0) begin : g_direct
         assign tick = run;
      end else begin : g_div
         logic [SHIFT-1:0] pre;
         always_ff @(posedge clk) begin
            if (!rst_n)    pre <= '0;
            else if (clr)  pre <= '0;
            else if (run)  pre <= pre + 1'b1;
         end
         assign tick = run && (pre == {SHIFT{1'b1}});
      end
   endgenerate
endmodule

// File: rtl/bw_unit_timer.sv
// Counts completed units; flags expiry on the tick that completes the limit.
module bw_unit_timer #(
   parameter int LIMIT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               tick,
   input  logic [LIMIT_W-1:0] limit_units,
   output logic               expire
);
   localparam int CNT_W = LIMIT_W + 1;

   logic [CNT_W-1:0] units;
   logic [CNT_W-1:0] lim_eff;

   always_comb begin
      if (limit_units == '0) lim_eff = CNT_W'(1) << LIMIT_W;
      else                   lim_eff = {1'b0, limit_units};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     units <= '0;
      else if (clr)   units <= '0;
      else if (tick)  units <= units + 1'b1;
   end

   assign expire = tick && (units == lim_eff - 1'b1);
endmodule

// File: rtl/bw_phase_ctl.sv
// Tracks the access phase and issues the error strobe on expiry.
module bw_phase_ctl
   import bw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mon_en,
   input  logic      xfer_start,
   input  logic      aack,
   input  logic      dack,
   input  logic      expire,
   output bw_phase_e phase,
   output logic      timer_clr,
   output logic      timer_run,
   output logic      err_q
);
   bw_phase_e ph_nxt;
   logic      fire;
   logic      waiting;

   always_comb begin
      waiting = ((phase == PH_ADDR) && !aack) || ((phase == PH_DATA) && !dack);
      ph_nxt  = phase;
      fire    = 1'b0;
      if (!mon_en) begin
         ph_nxt = PH_IDLE;
      end else begin
         unique case (phase)
            PH_IDLE: if (xfer_start) ph_nxt = PH_ADDR;
            PH_ADDR: begin
               if (aack)        ph_nxt = dack ? PH_IDLE : PH_DATA;
               else if (expire) begin ph_nxt = PH_IDLE; fire = 1'b1; end
            end
            PH_DATA: begin
               if (dack)        ph_nxt = PH_IDLE;
               else if (expire) begin ph_nxt = PH_IDLE; fire = 1'b1; end
            end
            default: ph_nxt = PH_IDLE;
         endcase
      end
      timer_run = mon_en && waiting;
      timer_clr = (ph_nxt != phase) || (phase == PH_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         err_q <= 1'b0;
      end else begin
         phase <= ph_nxt;
         err_q <= fire;
      end
   end
endmodule

// File: rtl/bus_ack_watchdog.sv
module bus_ack_watchdog
   import bw_pkg::*;
#(
   parameter int LIMIT_W    = 8,
   parameter int UNIT_SHIFT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mon_en,
   input  logic               xfer_start,
   input  logic               aack,
   input  logic               dack,
   input  logic [LIMIT_W-1:0] limit_units,
   output logic               xfer_err
);
   generate
      if (LIMIT_W < 1 || LIMIT_W > 16) begin : g_bad_limit_w
         $error("LIMIT_W must lie in 1..16");
      end
      if (UNIT_SHIFT < 0 || UNIT_SHIFT > 12) begin : g_bad_shift
         $error("UNIT_SHIFT must lie in 0..12");
      end
   endgenerate

   bw_phase_e ph;
   logic      t_clr;
   logic      t_run;
   logic      t_tick;
   logic      t_expire;

   bw_phase_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mon_en     (mon_en),
      .xfer_start (xfer_start),
      .aack       (aack),
      .dack       (dack),
      .expire     (t_expire),
      .phase      (ph),
      .timer_clr  (t_clr),
      .timer_run  (t_run),
      .err_q      (xfer_err)
   );

   bw_tick_gen #(.SHIFT(UNIT_SHIFT)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (t_clr),
      .run   (t_run),
      .tick  (t_tick)
   );

   bw_unit_timer #(.LIMIT_W(LIMIT_W)) u_units (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (t_clr),
      .tick        (t_tick),
      .limit_units (limit_units),
      .expire      (t_expire)
   );
endmodule

// File: rtl/bw_checker.sv
module bw_checker
   import bw_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      mon_en,
   input logic      aack,
   input logic      dack,
   input logic      xfer_err,
   input bw_phase_e phase
);
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |=> !xfer_err);

   a_r9_idle_after_err: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |-> (phase == PH_IDLE));

   a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_en |=> !xfer_err);

   a_r3_aack_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ADDR && aack) |=> !xfer_err);

   a_r5_dack_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && dack) |=> (!xfer_err && phase == PH_IDLE));

   a_r10_both_close: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ADDR && aack && dack) |=> (phase == PH_IDLE));

   a_r2_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_err) |-> ($past(phase) != PH_IDLE));
endmodule

bind bus_ack_watchdog bw_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mon_en   (mon_en),
   .aack     (aack),
   .dack     (dack),
   .xfer_err (xfer_err),
   .phase    (ph)
);

// File: tb/sim_bus_ack_watchdog.sv
module sim_bus_ack_watchdog;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mon_en = 1'b1;
   logic          xfer_start = 1'b0;
   logic          aack = 1'b0;
   logic          dack = 1'b0;
   logic [LW-1:0] limit_units = 8'd2;
   logic          xfer_err;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   string cur_req = "R1";

   typedef struct {
      int    at;
      string req;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   bus_ack_watchdog #(.LIMIT_W(LW), .UNIT_SHIFT(3)) u0 (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .xfer_start(xfer_start),
      .aack(aack), .dack(dack), .limit_units(limit_units), .xfer_err(xfer_err)
   );

   // monitor: every error strobe must match the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && xfer_err) begin
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL %s unexpected error at cycle %0d actual=1 expected=0", cur_req, cyc);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.at != cyc) begin
               bad++;
               $display("FAIL %s error cycle actual=%0d expected=%0d", e.req, cyc, e.at);
            end
         end
      end
   end

   function automatic int lim_clocks();
      return ((limit_units == 0) ? 256 : int'(limit_units)) * 8;
   endfunction

   task automatic check_low(input string req);
      total++;
      if (xfer_err !== 1'b0) begin
         bad++;
         $display("FAIL %s xfer_err actual=%b expected=0", req, xfer_err);
      end
   endtask

   // aw/dw: edges after phase start on which the ack is sampled; dw==0 means dack with aack
   task automatic run_txn(input int aw, input int dw, input string req);
      int n, e0, a;
      n = lim_clocks();
      cur_req = req;
      @(negedge clk); xfer_start = 1'b1;
      @(negedge clk); xfer_start = 1'b0; e0 = cyc;
      if (aw > n) begin
         sb.push_back('{at: e0 + n, req: req});
         repeat (n + 1) @(negedge clk);
         check_low("R9");
         return;
      end
      repeat (aw - 1) @(negedge clk);
      aack = 1'b1;
      if (dw == 0) dack = 1'b1;
      @(negedge clk); aack = 1'b0; dack = 1'b0; a = e0 + aw;
      if (dw == 0) begin
         repeat (n + 2) @(negedge clk);
         check_low(req);
         return;
      end
      if (dw > n) begin
         sb.push_back('{at: a + n, req: req});
         repeat (n + 1) @(negedge clk);
         check_low("R9");
         return;
      end
      repeat (dw - 1) @(negedge clk);
      dack = 1'b1;
      @(negedge clk); dack = 1'b0;
      repeat (n + 2) @(negedge clk);
      check_low(req);
   endtask

   initial begin
      int n, e0;
      repeat (3) @(negedge clk);
      check_low("R1");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_low("R1");

      limit_units = 8'd2;
      run_txn(20, 1, "R2");     // address phase never acknowledged
      run_txn(16, 3, "R3");     // aack on the last allowed edge
      run_txn(1, 5, "R3");
      run_txn(2, 17, "R4");     // data phase stalls
      run_txn(5, 16, "R5");     // dack on the last allowed edge
      run_txn(4, 0, "R10");     // both acks together

      limit_units = 8'd1;
      run_txn(9, 1, "R2");
      run_txn(3, 9, "R4");

      // R9: idle period after a timeout produces nothing more
      cur_req = "R9";
      repeat (40) @(negedge clk);
      check_low("R9");

      // R8: second start inside an open access does not restart the timer
      limit_units = 8'd2;
      n = lim_clocks();
      cur_req = "R8";
      @(negedge clk); xfer_start = 1'b1;
      @(negedge clk); xfer_start = 1'b0; e0 = cyc;
      sb.push_back('{at: e0 + n, req: "R8"});
      repeat (5) @(negedge clk); xfer_start = 1'b1;
      @(negedge clk); xfer_start = 1'b0;
      repeat (n + 20) @(negedge clk);
      check_low("R8");

      // R7: disabled monitor stays quiet
      cur_req = "R7";
      mon_en = 1'b0;
      @(negedge clk); xfer_start = 1'b1;
      @(negedge clk); xfer_start = 1'b0;
      repeat (3 * n) @(negedge clk);
      check_low("R7");
      // R7: abandon an open access by dropping the enable
      mon_en = 1'b1;
      @(negedge clk); xfer_start = 1'b1;
      @(negedge clk); xfer_start = 1'b0;
      repeat (8) @(negedge clk); mon_en = 1'b0;
      repeat (2) @(negedge clk); mon_en = 1'b1;
      repeat (3 * n) @(negedge clk);
      check_low("R7");

      // R6: zero limit means 2048 clocks
      limit_units = 8'd0;
      run_txn(2100, 1, "R6");
      run_txn(2048, 1, "R6");

      repeat (4) @(negedge clk);
      total++;
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL %s missing errors actual=%0d expected=0", sb[0].req, sb.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5 * 200000);
      total++;
      bad++;
      $display("FAIL %s watchdog expired actual=hung expected=done", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule